// File: doc/BRIEF.md
# Six-Digit Decimal Stopwatch Counter

This block holds the value of a stopwatch as six packed BCD digits, covering 000000 to 999999 microseconds. The least significant digit weighs 1 us and the most significant weighs 100 ms. An internal prescaler divides the system clock into a one-cycle step enable, once every `TICK_CYCLES` clocks. The default of 50 gives a microsecond at a 50 MHz clock. No derived clock is created.

When running, the value moves by one on each step enable. Counting up wraps from the top value back to zero. Counting down stops at zero. A separate request adds one millisecond to the value, which lets a controller dial in a countdown duration. A clear request returns the value to zero. A zero flag reports when all digits are zero. Display decoding and the mode sequencing of the stopwatch belong to other blocks.

Top module: `bcd_stopwatch_counter`

## Requirements
- R1: `digitsOut` holds six BCD digits, each in the range 0 to 9. Bits [3:0] are the 1 us digit, bits [15:12] the 1 ms digit and bits [23:20] the 100 ms digit.
- R2: With `runEn` held high and no clear or add request, the value changes once every `TICK_CYCLES` clocks. The first change lands on the `TICK_CYCLES`-th rising edge at which `runEn` is sampled high.
- R3: Counting up (`countDown` low) is decimal with carries, so 000009 becomes 000010. The value 999999 becomes 000000.
- R4: Counting down (`countDown` high) is decimal with borrows, so 000010 becomes 000009. At 000000 the value stays at 000000.
- R5: `isZero` is high exactly when all six digits are zero.
- R6: Each clock cycle with `addMs` high (and `clearReq` low) adds 1000 to the value. The three lowest digits are left untouched. A value of 999xyz becomes 000xyz.
- R7: While `runEn` is low, the value holds. The prescaler restarts, so after resuming a full `TICK_CYCLES` period passes before the next step.
- R8: A cycle with `clearReq` high sets the value to 000000 at the next edge and restarts the prescaler.
- R9: Requests coinciding in one cycle are resolved by priority: clear first, then add, then a step. A step that loses is dropped, not deferred.
- R10: While `rstN` is low, the value is 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Synchronous clear of value and prescaler |
| runEn | input | 1 | Enables stepping; low pauses and restarts the prescaler |
| countDown | input | 1 | Step direction: 0 up, 1 down |
| addMs | input | 1 | Add one millisecond (1000) per asserted cycle |
| digitsOut | output | 24 | Packed BCD value, 1 us digit in the low nibble |
| isZero | output | 1 | High when the value is 000000 |

## Verification
The bench builds the block with `TICK_CYCLES` set to 4 and keeps the six digits and the millisecond digit position at their defaults. The short step period makes it practical to walk the full up wrap from 999000 through 999999 to zero. It also allows a full countdown of one millisecond to zero with saturation, and several thousand random cycles of pause, add and clear traffic, all within a compact run. The millisecond wrap is reached by issuing a thousand add requests.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // One-cycle strobes from the control half to the digit datapath.
  // At most one is high in any cycle.
  typedef struct packed {
    logic clearAll;
    logic addMilli;
    logic stepUp;
    logic stepDown;
  } swc_strobe_t;

endpackage

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int TICK_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearReq,
  input  logic        runEn,
  input  logic        countDown,
  input  logic        addMs,
  output swc_strobe_t strobes
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] preCnt;
  logic          atEnd;
  logic          tickPulse;

  assign atEnd     = (preCnt == LAST);
  assign tickPulse = runEn & atEnd;

  // Prescaler restarts on clear or pause, so no partial period survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (clearReq || !runEn) preCnt <= '0;
    else if (atEnd)             preCnt <= '0;
    else                        preCnt <= preCnt + 1'b1;
  end

  // Priority: clear, then add, then step.
  always_comb begin
    strobes.clearAll = clearReq;
    strobes.addMilli = addMs & ~clearReq;
    strobes.stepUp   = tickPulse & ~clearReq & ~addMs & ~countDown;
    strobes.stepDown = tickPulse & ~clearReq & ~addMs & countDown;
  end

  // R9: never more than one strobe at a time
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R2: steps are spaced apart when the period exceeds one cycle
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((TICK_CYCLES > 1) && (strobes.stepUp || strobes.stepDown))
      |=> !(strobes.stepUp || strobes.stepDown));

  // R7: the cycle after a pause can never step
  p_pause_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((TICK_CYCLES > 1) && !runEn) |=> !(strobes.stepUp || strobes.stepDown));

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter int MS_DIGIT   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  swc_strobe_t             strobes,
  output logic [NUM_DIGITS*4-1:0] valueOut,
  output logic                    zeroFlag
);

  localparam logic [NUM_DIGITS*4-1:0] ALL_NINES = {NUM_DIGITS{4'h9}};

  logic [NUM_DIGITS-1:0][3:0] digitQ;
  logic [NUM_DIGITS-1:0]      carryIn;
  logic [NUM_DIGITS-1:0]      borrowIn;

  assign valueOut = digitQ;
  assign zeroFlag = (digitQ == '0);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    localparam bit IS_MS = (g == MS_DIGIT);

    if (g == 0) begin : g_first
      assign carryIn[g]  = strobes.stepUp | (IS_MS & strobes.addMilli);
      assign borrowIn[g] = strobes.stepDown & ~zeroFlag;
    end else begin : g_chain
      assign carryIn[g]  = (carryIn[g-1] & (digitQ[g-1] == 4'd9))
                         | (IS_MS & strobes.addMilli);
      assign borrowIn[g] = borrowIn[g-1] & (digitQ[g-1] == 4'd0);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 digitQ[g] <= 4'd0;
      else if (strobes.clearAll) digitQ[g] <= 4'd0;
      else if (carryIn[g])       digitQ[g] <= (digitQ[g] == 4'd9) ? 4'd0 : digitQ[g] + 4'd1;
      else if (borrowIn[g])      digitQ[g] <= (digitQ[g] == 4'd0) ? 4'd9 : digitQ[g] - 4'd1;
    end

    // R1: each stage stays a legal decimal digit
    p_digit_bcd_r1: assert property (@(posedge clk) disable iff (!rstN)
      digitQ[g] <= 4'd9);
  end

  if (MS_DIGIT > 0) begin : g_low_keep
    // R6: an add leaves the sub-millisecond digits alone
    p_add_low_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes.addMilli |=> $stable(valueOut[MS_DIGIT*4-1:0]));
  end

  // R8: clear empties the value
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (valueOut == '0));

  // R4: counting down saturates at zero
  p_down_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (zeroFlag && strobes.stepDown) |=> zeroFlag);

  // R3: the top value wraps to zero on an up step
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepUp && valueOut == ALL_NINES) |=> zeroFlag);

  // R7: with no strobe the value holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(valueOut));

endmodule

// File: rtl/bcd_stopwatch_counter.sv
module bcd_stopwatch_counter
  import swc_pkg::*;
#(
  parameter int TICK_CYCLES = 50,
  parameter int NUM_DIGITS  = 6,
  parameter int MS_DIGIT    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clearReq,
  input  logic                    runEn,
  input  logic                    countDown,
  input  logic                    addMs,
  output logic [NUM_DIGITS*4-1:0] digitsOut,
  output logic                    isZero
);

  swc_strobe_t strobes;

  swc_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearReq  (clearReq),
    .runEn     (runEn),
    .countDown (countDown),
    .addMs     (addMs),
    .strobes   (strobes)
  );

  swc_datapath #(.NUM_DIGITS(NUM_DIGITS), .MS_DIGIT(MS_DIGIT)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .valueOut (digitsOut),
    .zeroFlag (isZero)
  );

endmodule

// File: tb/sim_bcd_stopwatch_counter.sv
module sim_bcd_stopwatch_counter;

  localparam int TICKS = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        clearReq, runEn, countDown, addMs;
  logic [23:0] digitsOut;
  logic        isZero;

  int checks = 0;
  int errors = 0;
  int refVal = 0;
  int refPre = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd_stopwatch_counter #(.TICK_CYCLES(TICKS), .NUM_DIGITS(6), .MS_DIGIT(3)) u0 (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .runEn(runEn),
    .countDown(countDown), .addMs(addMs), .digitsOut(digitsOut), .isZero(isZero)
  );

  function automatic logic [23:0] toBcd(int v);
    logic [23:0] r;
    int x;
    x = v;
    for (int i = 0; i < 6; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (digitsOut !== toBcd(refVal)) begin
      errors++;
      $display("FAIL %s value actual %h expected %h", tag, digitsOut, toBcd(refVal));
    end
    checks++;
    if (isZero !== (refVal == 0)) begin
      errors++;
      $display("FAIL R5 (%s) isZero actual %b expected %b", tag, isZero, refVal == 0);
    end
  endtask

  // Model of one clock edge, from the requirements.
  task automatic modelEdge(bit clr, bit run, bit dn, bit add);
    bit tick;
    if (clr) begin
      refVal = 0;
      refPre = 0;
    end else begin
      tick = run && (refPre == TICKS - 1);
      refPre = (!run || refPre == TICKS - 1) ? 0 : refPre + 1;
      if (add)
        refVal = ((refVal / 1000 + 1) % 1000) * 1000 + refVal % 1000;
      else if (tick) begin
        if (!dn)               refVal = (refVal + 1) % 1000000;
        else if (refVal != 0)  refVal = refVal - 1;
      end
    end
  endtask

  task automatic step(bit clr, bit run, bit dn, bit add);
    string tag;
    clearReq = clr; runEn = run; countDown = dn; addMs = add;
    @(posedge clk);
    modelEdge(clr, run, dn, add);
    @(negedge clk);
    tag = clr ? "R8" : add ? "R6" : !run ? "R7" : dn ? "R4" : "R3";
    compare(tag);
  endtask

  task automatic addMany(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  initial begin
    bit dirRand;
    rstN = 1'b0; clearReq = 0; runEn = 0; countDown = 0; addMs = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R10");
    rstN = 1'b1;

    // R2: first step lands on the TICKS-th run edge
    for (int i = 0; i < TICKS - 1; i++) step(0, 1, 0, 0);
    checks++;
    if (digitsOut !== 24'h0) begin
      errors++; $display("FAIL R2 early step actual %h expected %h", digitsOut, 24'h0);
    end
    step(0, 1, 0, 0);
    compare("R2");

    // R1/R3: decimal carry 9 -> 10
    while (refVal != 10) step(0, 1, 0, 0);
    compare("R1");

    // R7: pause holds, resume takes a full period
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
    compare("R7");
    for (int i = 0; i < TICKS - 1; i++) step(0, 1, 0, 0);
    checks++;
    if (digitsOut !== 24'h000010) begin
      errors++; $display("FAIL R7 resume actual %h expected %h", digitsOut, 24'h000010);
    end
    step(0, 1, 0, 0);
    compare("R7");

    // R9: clear beats add; add beats a coinciding step
    step(1, 1, 0, 1);
    compare("R9");
    while (refPre != TICKS - 1) step(0, 1, 0, 0);
    step(0, 1, 0, 1);
    compare("R9");
    checks++;
    if (digitsOut !== toBcd(refVal) || digitsOut[3:0] !== toBcd(refVal - 1000)[3:0] + 4'd0) begin
      errors++; $display("FAIL R9 step not dropped actual %h expected %h", digitsOut, toBcd(refVal));
    end

    // R6: millisecond preset wraps from 999000
    step(1, 0, 0, 0);
    addMany(999);
    compare("R6");
    step(0, 0, 0, 1);
    compare("R6");

    // R3: up count through 999999 to zero
    addMany(999);
    while (refVal != 999999) step(0, 1, 0, 0);
    compare("R3");
    while (refVal != 0) step(0, 1, 0, 0);
    compare("R3");

    // R4: countdown of one millisecond, then saturation at zero
    step(1, 0, 1, 0);
    step(0, 0, 1, 1);
    while (refVal != 0) step(0, 1, 1, 0);
    compare("R4");
    for (int i = 0; i < 3 * TICKS; i++) step(0, 1, 1, 0);
    compare("R4");

    // Random traffic
    dirRand = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) dirRand = ~dirRand;
      step($urandom_range(0, 49) == 0, $urandom_range(0, 9) != 0,
           dirRand, $urandom_range(0, 15) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule